// File: doc/BRIEF.md
# Edit Distance Score Accumulator

This block sits after the final processing element of a linear systolic array that computes edit distance. Each cell of that array carries only a single bit per table entry. The bit tells whether the next entry of the rightmost column is one above or one below the entry before it. The accumulator turns that stream of steps back into a whole score, so the full score never travels between array stages.

Before each comparison the host preloads the counter with the length of the stored string, which is the value of the table's top-right cell. The array then streams the target string. Each accepted step bit moves the count by one: a 1 moves it up and a 0 moves it down. The row that carries the end marker closes the comparison. One cycle later a done flag rises, and the score stays frozen until the next preload. The default build uses a 13-bit score capped at 8064.

Top module: `edit_score_acc`

## Requirements
- R1: While `rst_ni` is low, `score_o` is 0 and `done_o` is 0.
- R2: When `load_i` is high at a clock edge, `score_o` equals `load_val_i` after that edge and `done_o` is 0.
- R3: When `step_vld_i` is high, `step_i` is 1, `load_i` is low and `done_o` is low, `score_o` rises by one after the edge.
- R4: When `step_vld_i` is high, `step_i` is 0, `load_i` is low and `done_o` is low, `score_o` falls by one after the edge.
- R5: When `step_vld_i` is low, `step_i` and `last_i` have no effect: `score_o` and `done_o` hold their values.
- R6: When `load_i` is high, any step presented in the same cycle is discarded, including its `last_i` marker.
- R7: `done_o` rises on the edge that accepts a step with `last_i` high. While `done_o` is high and `load_i` is low, further steps are ignored and `score_o` holds.
- R8: `score_o` stays within 0 to `SCORE_MAX`. A down step at 0 leaves it at 0, and an up step at `SCORE_MAX` leaves it at `SCORE_MAX`.
- R9: If the counter is preloaded with the length m of S and fed the steps D[i][m] - D[i-1][m] for i = 1 to n (1 for +1, 0 for -1), then `score_o` ends at D[n][m]. Here D is the edit-distance table with insertion and deletion costing 1 and substitution costing 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Preload strobe |
| load_val_i | input | SCORE_W | Preload value (length of S), at most SCORE_MAX |
| step_vld_i | input | 1 | Step bit valid |
| step_i | input | 1 | Step direction: 1 up, 0 down |
| last_i | input | 1 | Marks the step of the final T row |
| score_o | output | SCORE_W | Running score, final once done_o is high |
| done_o | output | 1 | Comparison complete |

## Verification
The bench builds the block with SCORE_W = 6 and SCORE_MAX = 40. With these values both clamp boundaries can be reached in a few dozen steps, and the up clamp sits below the width limit rather than at it. The real edit-distance tables the bench uses for string pairs up to 12 symbols stay inside that range. A behavioural model is compared every cycle, and it covers stalls in the step stream, a preload colliding with a step, and steps arriving after done.

// File: rtl/esa_pkg.sv
package esa_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_LOAD = 2'd3
  } step_cmd_e;
endpackage

// File: rtl/esa_step_decode.sv
module esa_step_decode
  import esa_pkg::*;
(
  input  logic      load_i,
  input  logic      vld_i,
  input  logic      dir_i,
  input  logic      done_i,
  output step_cmd_e cmd_o
);
  always_comb begin
    if (load_i)               cmd_o = STEP_LOAD;
    else if (vld_i && !done_i) cmd_o = dir_i ? STEP_UP : STEP_DOWN;
    else                      cmd_o = STEP_HOLD;
  end
endmodule

// File: rtl/esa_sat_counter.sv
module esa_sat_counter
  import esa_pkg::*;
#(
  parameter int unsigned W   = 13,
  parameter int unsigned MAX = 8064
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  step_cmd_e    cmd_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MaxV = W'(MAX);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      case (cmd_i)
        STEP_LOAD: cnt_q <= load_val_i;
        STEP_UP:   if (cnt_q != MaxV) cnt_q <= cnt_q + 1'b1;
        STEP_DOWN: if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/esa_done_track.sv
module esa_done_track
  import esa_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  step_cmd_e cmd_i,
  input  logic      last_i,
  output logic      done_o
);
  logic done_q;
  logic take_last;

  // a last marker counts only with a step that is actually consumed
  assign take_last = last_i && (cmd_i == STEP_UP || cmd_i == STEP_DOWN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 done_q <= 1'b0;
    else if (cmd_i == STEP_LOAD) done_q <= 1'b0;
    else if (take_last)          done_q <= 1'b1;
  end

  assign done_o = done_q;
endmodule

// File: rtl/edit_score_acc.sv
module edit_score_acc
  import esa_pkg::*;
#(
  parameter int unsigned SCORE_W   = 13,
  parameter int unsigned SCORE_MAX = 8064
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [SCORE_W-1:0] load_val_i,
  input  logic               step_vld_i,
  input  logic               step_i,
  input  logic               last_i,
  output logic [SCORE_W-1:0] score_o,
  output logic               done_o
);
  step_cmd_e cmd;
  logic      done;

  esa_step_decode i_decode (
    .load_i (load_i),
    .vld_i  (step_vld_i),
    .dir_i  (step_i),
    .done_i (done),
    .cmd_o  (cmd)
  );

  esa_sat_counter #(
    .W   (SCORE_W),
    .MAX (SCORE_MAX)
  ) i_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .load_val_i (load_val_i),
    .cnt_o      (score_o)
  );

  esa_done_track i_done (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (cmd),
    .last_i (last_i),
    .done_o (done)
  );

  assign done_o = done;
endmodule

// File: rtl/edit_score_acc_chk.sv
module edit_score_acc_chk #(
  parameter int unsigned SCORE_W   = 13,
  parameter int unsigned SCORE_MAX = 8064
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic [SCORE_W-1:0] load_val_i,
  input logic               step_vld_i,
  input logic               step_i,
  input logic               last_i,
  input logic [SCORE_W-1:0] score_o,
  input logic               done_o
);
  localparam logic [SCORE_W-1:0] MaxV = SCORE_W'(SCORE_MAX);

  AST_RESET_CLEAR: assert property (@(posedge clk_i) !rst_ni |-> (score_o == '0 && !done_o)); // R1
  AST_LOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (score_o == $past(load_val_i) && !done_o)); // R2
  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_vld_i && step_i && !done_o && score_o != MaxV)
      |=> ({1'b0, score_o} == {1'b0, $past(score_o)} + 1'b1)); // R3
  AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_vld_i && !step_i && !done_o && score_o != '0)
      |=> ({1'b0, score_o} + 1'b1 == {1'b0, $past(score_o)})); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_vld_i) |=> ($stable(score_o) && $stable(done_o))); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(step_vld_i && last_i && !load_i)); // R7
  AST_DONE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !load_i) |=> (done_o && $stable(score_o))); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    score_o <= MaxV); // R8
  AST_FLOOR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && score_o == '0) |=> score_o <= SCORE_W'(1)); // R8
endmodule

bind edit_score_acc edit_score_acc_chk #(
  .SCORE_W   (SCORE_W),
  .SCORE_MAX (SCORE_MAX)
) i_edit_score_acc_chk (.*);

// File: tb/test_edit_score_acc.sv
`timescale 1ns/1ps
module test_edit_score_acc;
  localparam int W   = 6;
  localparam int MAX = 40;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [W-1:0] load_val_i = '0;
  logic         step_vld_i = 1'b0;
  logic         step_i = 1'b0;
  logic         last_i = 1'b0;
  logic [W-1:0] score_o;
  logic         done_o;

  always #2.5 clk_i = ~clk_i;

  edit_score_acc #(.SCORE_W(W), .SCORE_MAX(MAX)) i_edit_score_acc (.*);

  int n_cmp = 0;
  int n_bad = 0;
  int m_sc  = 0;
  bit m_dn  = 1'b0;
  int unsigned seed = 32'h1234_5678;
  int s_str [16];
  int t_str [16];
  int dtab [0:15][0:15];

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 16;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge, compare after it
  task automatic cyc(bit ld, int val, bit v, bit d, bit l, string tag);
    @(negedge clk_i);
    load_i = ld; load_val_i = W'(val); step_vld_i = v; step_i = d; last_i = l;
    @(posedge clk_i);
    if (ld) begin
      m_sc = val; m_dn = 1'b0;
    end else if (v && !m_dn) begin
      if (d) m_sc = (m_sc == MAX) ? MAX : m_sc + 1;
      else   m_sc = (m_sc == 0) ? 0 : m_sc - 1;
      if (l) m_dn = 1'b1;
    end
    #1;
    chk(tag, int'(score_o), m_sc);
    chk(tag, int'(done_o), int'(m_dn));
  endtask

  task automatic run_pair(int m, int n, bit stalls);
    for (int i = 0; i <= n; i++) dtab[i][0] = i;
    for (int j = 0; j <= m; j++) dtab[0][j] = j;
    for (int i = 1; i <= n; i++)
      for (int j = 1; j <= m; j++) begin
        int best;
        best = dtab[i-1][j-1] + ((s_str[j-1] == t_str[i-1]) ? 0 : 2);
        if (dtab[i-1][j] + 1 < best) best = dtab[i-1][j] + 1;
        if (dtab[i][j-1] + 1 < best) best = dtab[i][j-1] + 1;
        dtab[i][j] = best;
      end
    cyc(1, m, 0, 0, 0, "R2");
    for (int i = 1; i <= n; i++) begin
      if (stalls && (rnd() % 3 == 0)) cyc(0, 0, 0, rnd() % 2, 1, "R5");
      cyc(0, 0, 1, dtab[i][m] > dtab[i-1][m], i == n,
          (dtab[i][m] > dtab[i-1][m]) ? "R3" : "R4");
    end
    chk("R9", int'(score_o), dtab[n][m]);
    cyc(0, 0, 1, 1, 0, "R7");
    chk("R9", int'(score_o), dtab[n][m]);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1", int'(score_o), 0);
    chk("R1", int'(done_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // basic steps, idle cycles with noise on the qualified pins
    cyc(1, 10, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 0, 1, 1, "R5");
    cyc(0, 0, 0, 0, 1, "R5");
    chk("R5", int'(score_o), 11);

    // preload collides with a step carrying the last marker
    cyc(1, 7, 1, 1, 1, "R6");
    chk("R6", int'(score_o), 7);
    chk("R6", int'(done_o), 0);

    // floor clamp
    cyc(1, 1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, "R4");
    cyc(0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 1, 0, 0, "R8");
    chk("R8", int'(score_o), 0);

    // ceiling clamp
    cyc(1, MAX - 1, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, "R3");
    cyc(0, 0, 1, 1, 0, "R8");
    chk("R8", int'(score_o), MAX);
    cyc(0, 0, 1, 0, 0, "R4");

    // done raising and freezing
    cyc(1, 5, 0, 0, 0, "R2");
    cyc(0, 0, 1, 1, 0, "R3");
    chk("R7", int'(done_o), 0);
    cyc(0, 0, 1, 0, 1, "R7");
    chk("R7", int'(done_o), 1);
    cyc(0, 0, 1, 1, 0, "R7");
    cyc(0, 0, 1, 0, 1, "R7");
    chk("R7", int'(score_o), 5);
    cyc(1, 3, 0, 0, 0, "R2");
    chk("R2", int'(done_o), 0);

    // identical strings: score 0
    for (int k = 0; k < 6; k++) begin s_str[k] = k % 4; t_str[k] = k % 4; end
    run_pair(6, 6, 1'b0);

    // fully different strings
    for (int k = 0; k < 5; k++) begin s_str[k] = 0; t_str[k] = 3; end
    run_pair(5, 5, 1'b1);

    // single-symbol target against longer S
    for (int k = 0; k < 8; k++) s_str[k] = k % 4;
    t_str[0] = 2;
    run_pair(8, 1, 1'b0);

    // pseudo-random pairs of varying lengths with stalls
    for (int p = 0; p < 40; p++) begin
      int m;
      int n;
      m = 1 + int'(rnd() % 12);
      n = 1 + int'(rnd() % 12);
      for (int k = 0; k < m; k++) s_str[k] = int'(rnd() % 4);
      for (int k = 0; k < n; k++) t_str[k] = int'(rnd() % 4);
      run_pair(m, n, 1'b1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule